// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This is a purely combinational datapath slice for an 8-bit processor core. It carries out the circular rotates, the rotates through carry, the arithmetic and logical shifts, the nibble swap, and the single-bit test, clear and set operations. The core's decoder supplies a 4-bit operation code, a bit index and the operand. The core's flag register supplies the incoming carry. The unit returns the new value, four flag values (zero, subtract, half-carry, carry) and write enables. The enables tell the core which flags to update and whether to store the result.

The accumulator-only rotates share their datapath with the general rotates. They differ in one way: they always clear the zero flag, whatever the result. Bit test only reads its operand. It defines zero, subtract and half-carry, and it leaves carry alone. Bit clear and bit set change the operand and no flag. Operand fetch and writeback belong to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: Operation codes 4 (general) and 0 (accumulator) perform a circular rotate left. Old bit 7 goes to result bit 0, and it also goes to C.
- R2: Operation codes 5 (general) and 1 (accumulator) perform a circular rotate right. Old bit 0 goes to result bit 7, and it also goes to C.
- R3: Operation codes 6 (general) and 2 (accumulator) rotate left through carry. The incoming carry enters bit 0, and old bit 7 goes to C.
- R4: Operation codes 7 (general) and 3 (accumulator) rotate right through carry. The incoming carry enters bit 7, and old bit 0 goes to C.
- R5: Operation code 8 shifts left. Bit 0 is filled with zero, and old bit 7 goes to C.
- R6: Operation code 9 shifts right arithmetically: bit 7 is kept. Operation code 11 shifts right logically: bit 7 is filled with zero. Both put old bit 0 into C.
- R7: Operation code 10 exchanges the upper and lower nibbles and clears C.
- R8: Every operation with code 0 to 11 clears N and H. Codes 4 to 11 set Z exactly when the result is zero. `flag_we` is ordered {Z,N,H,C}; for codes 0 to 11 it is 4'b1111, and `result_we` is 1.
- R9: The accumulator rotates (codes 0 to 3) drive Z to 0 for every result, including a zero result.
- R10: Operation code 12 tests bit `bit_sel` of the operand. It drives Z to the inverse of that bit, H to 1 and N to 0. `flag_c` carries `carry_in` through unchanged, `flag_we` is 4'b1110, `result_we` is 0, and `result` equals the operand.
- R11: Operation code 13 clears bit `bit_sel` and operation code 14 sets it. Both leave every other bit as it was, drive `flag_we` to 4'b0000 and drive `result_we` to 1.
- R12: Operation code 15 writes nothing: `flag_we` is 0 and `result_we` is 0. `result` equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select (encodings listed in the requirements) |
| bit_sel | input | 3 | Bit index for test, clear and set |
| operand | input | 8 | Source value |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | New value for the destination |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Subtract flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_c | output | 1 | Carry flag value |
| flag_we | output | 4 | Flag write enables, {Z,N,H,C} |
| result_we | output | 1 | Result write enable |

## Verification
The assertions are immediate checks in the combinational blocks. They assume that the operation code, bit index, operand and carry are all stable, known values whenever the block is evaluated. They also assume that every 4-bit code is legal, with code 15 defined as a no-write operation. The bench drives each input only on the falling clock edge and samples one nanosecond later. Every code it drives is one of the sixteen defined values, and each bit index is within 0 to 7, so no input is ever unknown while an assertion evaluates.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [3:0] {
        OP_ACC_RLC = 4'd0,
        OP_ACC_RRC = 4'd1,
        OP_ACC_RL  = 4'd2,
        OP_ACC_RR  = 4'd3,
        OP_RLC     = 4'd4,
        OP_RRC     = 4'd5,
        OP_RL      = 4'd6,
        OP_RR      = 4'd7,
        OP_SLA     = 4'd8,
        OP_SRA     = 4'd9,
        OP_SWAP    = 4'd10,
        OP_SRL     = 4'd11,
        OP_BTST    = 4'd12,
        OP_BCLR    = 4'd13,
        OP_BSET    = 4'd14,
        OP_NONE    = 4'd15
    } rsb_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } rsb_flags_t;

    localparam rsb_flags_t WE_ALL  = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
    localparam rsb_flags_t WE_TEST = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
    localparam rsb_flags_t WE_NONE = '{z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b0};

    function automatic logic is_acc_rot(input rsb_op_e op);
        return op inside {OP_ACC_RLC, OP_ACC_RRC, OP_ACC_RL, OP_ACC_RR};
    endfunction

    function automatic logic is_shifter(input rsb_op_e op);
        return op <= OP_SRL;
    endfunction

    function automatic logic is_bitop(input rsb_op_e op);
        return op inside {OP_BTST, OP_BCLR, OP_BSET};
    endfunction

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  rsb_op_e           op,
    input  logic [WIDTH-1:0]  opnd,
    input  logic              cin,
    output logic [WIDTH-1:0]  res,
    output logic              cout
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    always_comb begin
        res  = opnd;
        cout = cin;
        unique case (op)
            OP_ACC_RLC, OP_RLC: begin
                res  = {opnd[MSB-1:0], opnd[MSB]};
                cout = opnd[MSB];
            end
            OP_ACC_RRC, OP_RRC: begin
                res  = {opnd[0], opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_ACC_RL, OP_RL: begin
                res  = {opnd[MSB-1:0], cin};
                cout = opnd[MSB];
            end
            OP_ACC_RR, OP_RR: begin
                res  = {cin, opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SLA: begin
                res  = {opnd[MSB-1:0], 1'b0};
                cout = opnd[MSB];
            end
            OP_SRA: begin
                res  = {opnd[MSB], opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SRL: begin
                res  = {1'b0, opnd[MSB:1]};
                cout = opnd[0];
            end
            OP_SWAP: begin
                res  = {opnd[HALF-1:0], opnd[MSB:HALF]};
                cout = 1'b0;
            end
            default: begin
                res  = opnd;
                cout = cin;
            end
        endcase

        // R1
        rlc_wrap_chk: assert (!(op inside {OP_ACC_RLC, OP_RLC}) ||
                              (cout == res[0] && $countones(res) == $countones(opnd)));
        // R2
        rrc_wrap_chk: assert (!(op inside {OP_ACC_RRC, OP_RRC}) ||
                              (cout == res[MSB] && $countones(res) == $countones(opnd)));
        // R7
        swap_carry_chk: assert (op != OP_SWAP ||
                                (!cout && $countones(res) == $countones(opnd)));
    end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  rsb_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WIDTH-1:0]  opnd,
    output logic [WIDTH-1:0]  res,
    output logic              zero
);
    logic [WIDTH-1:0] sel;

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign sel[i] = (idx == IDX_W'(i));
    end

    always_comb begin
        zero = ~|(opnd & sel);
        unique case (op)
            OP_BCLR: res = opnd & ~sel;
            OP_BSET: res = opnd | sel;
            default: res = opnd;
        endcase

        // R10
        btst_keep_chk: assert (op != OP_BTST || (res == opnd && zero == !opnd[idx]));
        // R11
        bclr_bit_chk: assert (op != OP_BCLR ||
                              (!res[idx] && $countones(res ^ opnd) <= 1));
        // R11
        bset_bit_chk: assert (op != OP_BSET ||
                              (res[idx] && $countones(res ^ opnd) <= 1));
    end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [WIDTH-1:0]  operand,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c,
    output logic [3:0]        flag_we,
    output logic              result_we
);
    rsb_op_e          op;
    logic [WIDTH-1:0] sh_res;
    logic             sh_c;
    logic [WIDTH-1:0] bt_res;
    logic             bt_zero;
    rsb_flags_t       flags;
    rsb_flags_t       we;

    assign op = rsb_op_e'(op_code);

    rsb_shifter #(.WIDTH(WIDTH)) u_shifter (
        .op   (op),
        .opnd (operand),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    rsb_bitop #(.WIDTH(WIDTH)) u_bitop (
        .op   (op),
        .idx  (bit_sel),
        .opnd (operand),
        .res  (bt_res),
        .zero (bt_zero)
    );

    always_comb begin
        result    = operand;
        flags     = '{z: 1'b0, n: 1'b0, h: 1'b0, c: carry_in};
        we        = WE_NONE;
        result_we = 1'b0;

        if (is_shifter(op)) begin
            result    = sh_res;
            flags.c   = sh_c;
            flags.z   = is_acc_rot(op) ? 1'b0 : (sh_res == '0);
            we        = WE_ALL;
            result_we = 1'b1;
        end else if (op == OP_BTST) begin
            flags.z   = bt_zero;
            flags.h   = 1'b1;
            we        = WE_TEST;
        end else if (is_bitop(op)) begin
            result    = bt_res;
            result_we = 1'b1;
        end

        // R9
        acc_zero_chk: assert (!is_acc_rot(op) || !flags.z);
        // R8
        shift_nh_chk: assert (!is_shifter(op) || (!flags.n && !flags.h && we == WE_ALL));
        // R10
        btst_nowrite_chk: assert (op != OP_BTST || (!result_we && flags.c == carry_in));
        // R12
        none_idle_chk: assert (op != OP_NONE || (!result_we && we == WE_NONE));
    end

    assign flag_z  = flags.z;
    assign flag_n  = flags.n;
    assign flag_h  = flags.h;
    assign flag_c  = flags.c;
    assign flag_we = we;

endmodule

// File: tb/test_rsb_unit.sv
module test_rsb_unit;

    logic       clk = 1'b0;
    logic [3:0] op_code = 4'd15;
    logic [2:0] bit_sel = 3'd0;
    logic [7:0] operand = 8'h00;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       flag_z, flag_n, flag_h, flag_c;
    logic [3:0] flag_we;
    logic       result_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rsb_unit i_rsb_unit (
        .op_code   (op_code),
        .bit_sel   (bit_sel),
        .operand   (operand),
        .carry_in  (carry_in),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_h    (flag_h),
        .flag_c    (flag_c),
        .flag_we   (flag_we),
        .result_we (result_we)
    );

    // Expected layout: {result[7:0], z, n, h, c, we[3:0], result_we}
    task automatic run(input string req, input logic [3:0] op, input logic [2:0] idx,
                       input logic [7:0] val, input logic cin, input logic [16:0] exp);
        logic [16:0] got;
        @(negedge clk);
        op_code  = op;
        bit_sel  = idx;
        operand  = val;
        carry_in = cin;
        #1;
        got = {result, flag_z, flag_n, flag_h, flag_c, flag_we, result_we};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d opnd=%h cin=%b: got %h expected %h",
                     req, op, val, cin, got, exp);
        end
    endtask

    function automatic logic [16:0] sh_exp(input logic [7:0] r, input logic z, input logic c);
        return {r, z, 1'b0, 1'b0, c, 4'b1111, 1'b1};
    endfunction

    task automatic t_idle;
        run("R12", 4'd15, 3'd0, 8'h3C, 1'b1, {8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0});
    endtask

    task automatic t_rlc;
        run("R1", 4'd4, 3'd0, 8'h85, 1'b0, sh_exp(8'h0B, 1'b0, 1'b1));
        run("R1", 4'd0, 3'd0, 8'h85, 1'b0, sh_exp(8'h0B, 1'b0, 1'b1));
        run("R8", 4'd4, 3'd0, 8'h00, 1'b1, sh_exp(8'h00, 1'b1, 1'b0));
    endtask

    task automatic t_rrc;
        run("R2", 4'd5, 3'd0, 8'h01, 1'b0, sh_exp(8'h80, 1'b0, 1'b1));
        run("R2", 4'd1, 3'd0, 8'h02, 1'b1, sh_exp(8'h01, 1'b0, 1'b0));
    endtask

    task automatic t_rl;
        run("R3", 4'd6, 3'd0, 8'h80, 1'b0, sh_exp(8'h00, 1'b1, 1'b1));
        run("R3", 4'd6, 3'd0, 8'h12, 1'b1, sh_exp(8'h25, 1'b0, 1'b0));
        run("R3", 4'd2, 3'd0, 8'h40, 1'b1, sh_exp(8'h81, 1'b0, 1'b0));
    endtask

    task automatic t_rr;
        run("R4", 4'd7, 3'd0, 8'h01, 1'b1, sh_exp(8'h80, 1'b0, 1'b1));
        run("R4", 4'd7, 3'd0, 8'h01, 1'b0, sh_exp(8'h00, 1'b1, 1'b1));
    endtask

    task automatic t_acc_zero;
        run("R9", 4'd3, 3'd0, 8'h01, 1'b0, sh_exp(8'h00, 1'b0, 1'b1));
        run("R9", 4'd0, 3'd0, 8'h00, 1'b0, sh_exp(8'h00, 1'b0, 1'b0));
    endtask

    task automatic t_shifts;
        run("R5", 4'd8,  3'd0, 8'hC1, 1'b1, sh_exp(8'h82, 1'b0, 1'b1));
        run("R5", 4'd8,  3'd0, 8'h80, 1'b0, sh_exp(8'h00, 1'b1, 1'b1));
        run("R6", 4'd9,  3'd0, 8'h81, 1'b0, sh_exp(8'hC0, 1'b0, 1'b1));
        run("R6", 4'd11, 3'd0, 8'h81, 1'b0, sh_exp(8'h40, 1'b0, 1'b1));
        run("R6", 4'd11, 3'd0, 8'h01, 1'b1, sh_exp(8'h00, 1'b1, 1'b1));
    endtask

    task automatic t_swap;
        run("R7", 4'd10, 3'd0, 8'hA5, 1'b1, sh_exp(8'h5A, 1'b0, 1'b0));
        run("R7", 4'd10, 3'd0, 8'h00, 1'b1, sh_exp(8'h00, 1'b1, 1'b0));
    endtask

    task automatic t_btst;
        run("R10", 4'd12, 3'd3, 8'h08, 1'b1, {8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, 1'b0});
        run("R10", 4'd12, 3'd7, 8'h7F, 1'b0, {8'h7F, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110, 1'b0});
    endtask

    task automatic t_bclr_bset;
        run("R11", 4'd13, 3'd0, 8'hFF, 1'b1, {8'hFE, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b1});
        run("R11", 4'd13, 3'd5, 8'h0F, 1'b0, {8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1});
        run("R11", 4'd14, 3'd7, 8'h00, 1'b0, {8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1});
    endtask

    initial begin
        t_idle;
        t_rlc;
        t_rrc;
        t_rl;
        t_rr;
        t_acc_zero;
        t_shifts;
        t_swap;
        t_btst;
        t_bclr_bset;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule